// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus. Every line holds one word, a tag and a two-bit coherence state. Local processor reads and writes are served from the line store when the state allows it. Otherwise the controller requests the bus, waits for a grant, places a read, a read-for-ownership, an invalidate (upgrade) or a write-back, and waits for the bus acknowledge.

At the same time the controller watches transactions placed by the other caches. It answers each one in the same cycle with a shared indication. When it holds the line dirty it also supplies the data. The line then moves down to Shared or Invalid as the snooped command requires.

Dirty lines are written back only when a miss evicts them. The transaction to issue is chosen at the moment the grant arrives, so a snoop that lands while the request waits for the bus is honoured.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid (state encoding I=00, S=01, E=10, M=11), `bus_req` and `cpu_resp_valid` are low, and the first read of any address issues a bus read.
- R2: A read miss whose fill is acknowledged with `bus_shared_in` low installs the line Exclusive and returns the fill word.
- R3: A read miss filled with `bus_shared_in` high installs the line Shared. Later reads of it hit with no bus traffic, and a snooped read of it asserts `snp_shared` without `snp_flush`.
- R4: A write to a Shared line requests the bus and issues an upgrade (`bus_cmd`=11) for the line's address. Only after the acknowledge does the line become Modified holding the new word.
- R5: A write hit on an Exclusive or Modified line completes without requesting the bus and leaves the line Modified.
- R6: A write miss issues a read-for-ownership (`bus_cmd`=10) and installs the line Modified with the written word.
- R7: A miss whose direct-mapped victim is Modified first issues a write-back (`bus_cmd`=00) carrying the victim's address and word. It then issues the fill for the new address (read `bus_cmd`=01 or read-for-ownership).
- R8: A snooped read (`snp_cmd`=01) hitting a Modified line asserts `snp_shared` and `snp_flush` with the line word on `snp_flush_data`, and leaves the line Shared. On an Exclusive line it asserts only `snp_shared` and leaves the line Shared, so a later local write needs an upgrade.
- R9: A snooped read-for-ownership (10) or upgrade (11) hitting a valid line asserts `snp_shared` (plus `snp_flush` with data when Modified) and makes the line Invalid.
- R10: A snoop whose tag differs from the stored tag, or that targets an Invalid line, or that carries a write-back (00), drives no response and changes no line.
- R11: `bus_req` stays high from the first request until the acknowledge, a command is placed only in a granted cycle, and a local request that needs the bus gets no response before its acknowledge.
- R12: If a pending upgrade loses its Shared copy to a snooped invalidate before the grant, the controller issues a read-for-ownership instead, and the line still ends Modified with the new word.
- R13: A snoop to the same line index as a local request in the same cycle is applied first, and the local request is evaluated against the post-snoop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local request, held until the response |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address: low IDX_W bits index, rest tag |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word, or written word for writes |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_valid | output | 1 | Command placed on the bus this cycle |
| bus_cmd | output | 2 | 00 write-back, 01 read, 10 read-for-ownership, 11 upgrade |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_data | output | DATA_W | Write-back word, zero otherwise |
| bus_ack | input | 1 | Current transaction complete |
| bus_fill_data | input | DATA_W | Fill word, valid with the acknowledge |
| bus_shared_in | input | 1 | Another cache holds the line, valid with the acknowledge |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Supplied word |

## Verification
The hardest situation to reach is a snooped invalidate that arrives while this cache waits for a grant on an upgrade. The bench withholds the grant, confirms that the request is held and the processor stalled, then snoops the invalidate. Only after that does it release the grant and expect a read-for-ownership. A second hard case is a snoop and a local write arriving on the same index in the same cycle. The bench forks both from one falling edge and expects the write to see the downgraded Shared state and issue an upgrade. Every line state is made visible only through ports: bus traffic or its absence on local accesses, and the shared and flush answers to later snoops.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   // Coherence state of one line
   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_E = 2'b10,
      ST_M = 2'b11
   } line_st_e;

   // Bus and snoop command codes
   typedef enum logic [1:0] {
      CMD_WB  = 2'b00,
      CMD_RD  = 2'b01,
      CMD_RDX = 2'b10,
      CMD_UPG = 2'b11
   } bus_cmd_e;

   // Local request sequencer
   typedef enum logic [1:0] {
      F_IDLE = 2'b00,
      F_BUS  = 2'b01,
      F_WAIT = 2'b10,
      F_RESP = 2'b11
   } fsm_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int TAG_W = 14,
   parameter int IDX_W = 2,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   // local lookup port
   input  logic [IDX_W-1:0] lk_idx,
   output line_st_e         lk_st,
   output logic [TAG_W-1:0] lk_tag,
   output logic [DW-1:0]    lk_data,
   // snoop lookup port
   input  logic [IDX_W-1:0] sn_idx,
   output line_st_e         sn_st,
   output logic [TAG_W-1:0] sn_tag,
   output logic [DW-1:0]    sn_data,
   // local write port
   input  logic             lw_en,
   input  logic [IDX_W-1:0] lw_idx,
   input  line_st_e         lw_st,
   input  logic [TAG_W-1:0] lw_tag,
   input  logic [DW-1:0]    lw_data,
   // snoop state write port, wins over the local state write
   input  logic             sw_en,
   input  logic [IDX_W-1:0] sw_idx,
   input  line_st_e         sw_st,
   // whole state vector, for checking
   output line_st_e         st_all [1<<IDX_W]
);

   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_r  [LINES];
   logic [DW-1:0]    data_r [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e         st_q;
      logic [TAG_W-1:0] tag_q;
      logic [DW-1:0]    data_q;
      logic             lw_hit;
      logic             sw_hit;

      assign lw_hit = lw_en && (lw_idx == IDX_W'(g));
      assign sw_hit = sw_en && (sw_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q   <= ST_I;
            tag_q  <= '0;
            data_q <= '0;
         end else begin
            if (lw_hit) begin
               tag_q  <= lw_tag;
               data_q <= lw_data;
            end
            if (sw_hit) begin
               st_q <= sw_st;
            end else if (lw_hit) begin
               st_q <= lw_st;
            end
         end
      end

      assign st_all[g] = st_q;
      assign tag_r[g]  = tag_q;
      assign data_r[g] = data_q;
   end

   assign lk_st   = st_all[lk_idx];
   assign lk_tag  = tag_r[lk_idx];
   assign lk_data = data_r[lk_idx];
   assign sn_st   = st_all[sn_idx];
   assign sn_tag  = tag_r[sn_idx];
   assign sn_data = data_r[sn_idx];

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
#(
   parameter int TAG_W = 14,
   parameter int DW    = 32
) (
   input  logic             snp_valid,
   input  bus_cmd_e         snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  line_st_e         ln_st,
   input  logic [TAG_W-1:0] ln_tag,
   input  logic [DW-1:0]    ln_data,
   output logic             hit,
   output logic             shared,
   output logic             flush,
   output logic [DW-1:0]    flush_data,
   output logic             sw_en,
   output line_st_e         sw_st
);

   always_comb begin
      hit        = snp_valid && (ln_st != ST_I) && (ln_tag == snp_tag)
                   && (snp_cmd != CMD_WB);
      shared     = hit;
      flush      = 1'b0;
      flush_data = '0;
      sw_en      = 1'b0;
      sw_st      = ln_st;
      unique case (snp_cmd)
         CMD_RD: begin
            // owner of a dirty copy supplies it; E and M drop to S
            flush = hit && (ln_st == ST_M);
            sw_en = hit && (ln_st != ST_S);
            sw_st = ST_S;
         end
         CMD_RDX: begin
            flush = hit && (ln_st == ST_M);
            sw_en = hit;
            sw_st = ST_I;
         end
         CMD_UPG: begin
            sw_en = hit;
            sw_st = ST_I;
         end
         default: begin
            sw_en = 1'b0;
         end
      endcase
      if (flush) flush_data = ln_data;
   end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 2,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DW-1:0]     cpu_req_wdata,
   output logic              cpu_resp_valid,
   output logic [DW-1:0]     cpu_resp_rdata,
   input  logic              snp_block,
   // line store lookup and write
   output logic [IDX_W-1:0]        lk_idx,
   input  line_st_e                ln_st,
   input  logic [ADDR_W-IDX_W-1:0] ln_tag,
   input  logic [DW-1:0]           ln_data,
   output logic                    lw_en,
   output line_st_e                lw_st,
   output logic [ADDR_W-IDX_W-1:0] lw_tag,
   output logic [DW-1:0]           lw_data,
   // bus side
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_cmd_valid,
   output bus_cmd_e          bus_cmd,
   output logic [ADDR_W-1:0] bus_cmd_addr,
   output logic [DW-1:0]     bus_cmd_data,
   input  logic              bus_ack,
   input  logic [DW-1:0]     bus_fill_data,
   input  logic              bus_shared_in
);

   localparam int TAG_W = ADDR_W - IDX_W;

   fsm_e             st_q, st_d;
   logic             q_wr;
   logic [TAG_W-1:0] q_tag;
   logic [IDX_W-1:0] q_idx;
   logic [DW-1:0]    q_wdata;
   bus_cmd_e         cmd_q, cmd_d;
   logic [DW-1:0]    rdata_q, rdata_d;
   logic             cap, rd_ld, hit;
   logic [TAG_W-1:0] cur_tag;

   always_comb begin
      if (st_q == F_IDLE) begin
         cur_tag = cpu_req_addr[ADDR_W-1:IDX_W];
         lk_idx  = cpu_req_addr[IDX_W-1:0];
      end else begin
         cur_tag = q_tag;
         lk_idx  = q_idx;
      end
      hit = (ln_st != ST_I) && (ln_tag == cur_tag);
   end

   // Command chosen from the line as it stands in the granted cycle
   always_comb begin
      if (ln_st == ST_M && ln_tag != q_tag) cmd_d = CMD_WB;
      else if (q_wr && hit && ln_st == ST_S) cmd_d = CMD_UPG;
      else if (q_wr)                         cmd_d = CMD_RDX;
      else                                   cmd_d = CMD_RD;
   end

   always_comb begin
      st_d    = st_q;
      cap     = 1'b0;
      rd_ld   = 1'b0;
      rdata_d = ln_data;
      lw_en   = 1'b0;
      lw_st   = ln_st;
      lw_tag  = ln_tag;
      lw_data = ln_data;
      unique case (st_q)
         F_IDLE: begin
            if (cpu_req_valid && !snp_block) begin
               cap = 1'b1;
               if (!cpu_req_write && hit) begin
                  rd_ld = 1'b1;
                  st_d  = F_RESP;
               end else if (cpu_req_write && hit &&
                            (ln_st == ST_M || ln_st == ST_E)) begin
                  lw_en   = 1'b1;
                  lw_st   = ST_M;
                  lw_data = cpu_req_wdata;
                  rd_ld   = 1'b1;
                  rdata_d = cpu_req_wdata;
                  st_d    = F_RESP;
               end else begin
                  st_d = F_BUS;
               end
            end
         end
         F_BUS: begin
            if (bus_gnt) st_d = F_WAIT;
         end
         F_WAIT: begin
            if (bus_ack) begin
               lw_en = 1'b1;
               unique case (cmd_q)
                  CMD_WB: begin
                     lw_st = ST_I;
                     st_d  = F_BUS;
                  end
                  CMD_RD: begin
                     lw_st   = bus_shared_in ? ST_S : ST_E;
                     lw_tag  = q_tag;
                     lw_data = bus_fill_data;
                     rd_ld   = 1'b1;
                     rdata_d = bus_fill_data;
                     st_d    = F_RESP;
                  end
                  default: begin
                     lw_st   = ST_M;
                     lw_tag  = q_tag;
                     lw_data = q_wdata;
                     rd_ld   = 1'b1;
                     rdata_d = q_wdata;
                     st_d    = F_RESP;
                  end
               endcase
            end
         end
         default: begin
            st_d = F_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= F_IDLE;
         q_wr    <= 1'b0;
         q_tag   <= '0;
         q_idx   <= '0;
         q_wdata <= '0;
         cmd_q   <= CMD_RD;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (cap) begin
            q_wr    <= cpu_req_write;
            q_tag   <= cpu_req_addr[ADDR_W-1:IDX_W];
            q_idx   <= cpu_req_addr[IDX_W-1:0];
            q_wdata <= cpu_req_wdata;
         end
         if (st_q == F_BUS && bus_gnt) cmd_q <= cmd_d;
         if (rd_ld) rdata_q <= rdata_d;
      end
   end

   assign cpu_resp_valid = (st_q == F_RESP);
   assign cpu_resp_rdata = rdata_q;
   assign bus_req        = (st_q == F_BUS) || (st_q == F_WAIT);
   assign bus_cmd_valid  = (st_q == F_BUS) && bus_gnt;
   assign bus_cmd        = cmd_d;
   assign bus_cmd_addr   = (cmd_d == CMD_WB) ? {ln_tag, q_idx} : {q_tag, q_idx};
   assign bus_cmd_data   = (cmd_d == CMD_WB) ? ln_data : '0;

   // R11: once raised, the request is held until the transaction is acknowledged
   a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req);

   // R11: completion is a single-cycle pulse
   a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_resp_valid |=> !cpu_resp_valid);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_resp_valid,
   output logic [DATA_W-1:0] cpu_resp_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_cmd_valid,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_cmd_addr,
   output logic [DATA_W-1:0] bus_cmd_data,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_fill_data,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush,
   output logic [DATA_W-1:0] snp_flush_data
);

   localparam int TAG_W = ADDR_W - IDX_W;
   localparam int LINES = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("IDX_W must lie in 1..10");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0] lk_idx;
   line_st_e         lk_st, sn_st, lw_st, sw_st;
   logic [TAG_W-1:0] lk_tag, sn_tag, lw_tag;
   logic [DATA_W-1:0] lk_data, sn_data, lw_data;
   logic             lw_en, sw_en, snp_hit, snp_block;
   bus_cmd_e         fsm_cmd, snp_cmd_e;
   line_st_e         st_all [LINES];
   logic [IDX_W-1:0] snp_idx;

   assign snp_idx   = snp_addr[IDX_W-1:0];
   assign snp_cmd_e = bus_cmd_e'(snp_cmd);
   // a snoop to the index a local request targets is serviced first
   assign snp_block = snp_valid && (snp_idx == cpu_req_addr[IDX_W-1:0]);

   mesi_line_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DW(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (lk_idx),
      .lk_st   (lk_st),
      .lk_tag  (lk_tag),
      .lk_data (lk_data),
      .sn_idx  (snp_idx),
      .sn_st   (sn_st),
      .sn_tag  (sn_tag),
      .sn_data (sn_data),
      .lw_en   (lw_en),
      .lw_idx  (lk_idx),
      .lw_st   (lw_st),
      .lw_tag  (lw_tag),
      .lw_data (lw_data),
      .sw_en   (sw_en),
      .sw_idx  (snp_idx),
      .sw_st   (sw_st),
      .st_all  (st_all)
   );

   mesi_snoop_resp #(.TAG_W(TAG_W), .DW(DATA_W)) u_snoop (
      .snp_valid  (snp_valid),
      .snp_cmd    (snp_cmd_e),
      .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
      .ln_st      (sn_st),
      .ln_tag     (sn_tag),
      .ln_data    (sn_data),
      .hit        (snp_hit),
      .shared     (snp_shared),
      .flush      (snp_flush),
      .flush_data (snp_flush_data),
      .sw_en      (sw_en),
      .sw_st      (sw_st)
   );

   mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DW(DATA_W)) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_req_valid  (cpu_req_valid),
      .cpu_req_write  (cpu_req_write),
      .cpu_req_addr   (cpu_req_addr),
      .cpu_req_wdata  (cpu_req_wdata),
      .cpu_resp_valid (cpu_resp_valid),
      .cpu_resp_rdata (cpu_resp_rdata),
      .snp_block      (snp_block),
      .lk_idx         (lk_idx),
      .ln_st          (lk_st),
      .ln_tag         (lk_tag),
      .ln_data        (lk_data),
      .lw_en          (lw_en),
      .lw_st          (lw_st),
      .lw_tag         (lw_tag),
      .lw_data        (lw_data),
      .bus_req        (bus_req),
      .bus_gnt        (bus_gnt),
      .bus_cmd_valid  (bus_cmd_valid),
      .bus_cmd        (fsm_cmd),
      .bus_cmd_addr   (bus_cmd_addr),
      .bus_cmd_data   (bus_cmd_data),
      .bus_ack        (bus_ack),
      .bus_fill_data  (bus_fill_data),
      .bus_shared_in  (bus_shared_in)
   );

   assign bus_cmd = fsm_cmd;

   // checking support: snooped index one cycle later
   logic [IDX_W-1:0] snp_idx_q;
   always_ff @(posedge clk) begin
      if (!rst_n) snp_idx_q <= '0;
      else        snp_idx_q <= snp_idx;
   end

   // R9: an invalidating snoop that hits leaves the line Invalid
   a_r9_snoop_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && (snp_cmd_e == CMD_RDX || snp_cmd_e == CMD_UPG))
      |=> (st_all[snp_idx_q] == ST_I));

   // R8: a snooped read that hits leaves the line Shared
   a_r8_snoop_read_shares: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_hit && snp_cmd_e == CMD_RD) |=> (st_all[snp_idx_q] == ST_S));

   // R4: an upgrade is placed only for a line still held Shared with matching tag
   a_r4_upgrade_on_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_valid && fsm_cmd == CMD_UPG)
      |-> (lk_st == ST_S && {lk_tag, lk_idx} == bus_cmd_addr));

   // R7: a write-back is placed only while the victim is still Modified
   a_r7_writeback_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_valid && fsm_cmd == CMD_WB) |-> (lk_st == ST_M));

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;

   localparam int CLK_P  = 10;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 2;

   localparam logic [1:0] C_WB  = 2'b00;
   localparam logic [1:0] C_RD  = 2'b01;
   localparam logic [1:0] C_RDX = 2'b10;
   localparam logic [1:0] C_UPG = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
   logic [ADDR_W-1:0] cpu_req_addr = '0;
   logic [DATA_W-1:0] cpu_req_wdata = '0;
   logic cpu_resp_valid;
   logic [DATA_W-1:0] cpu_resp_rdata;
   logic bus_req, bus_cmd_valid;
   logic bus_gnt = 1'b0, bus_ack = 1'b0, bus_shared_in = 1'b0;
   logic [1:0] bus_cmd;
   logic [ADDR_W-1:0] bus_cmd_addr;
   logic [DATA_W-1:0] bus_cmd_data;
   logic [DATA_W-1:0] bus_fill_data = '0;
   logic snp_valid = 1'b0;
   logic [1:0] snp_cmd = 2'b00;
   logic [ADDR_W-1:0] snp_addr = '0;
   logic snp_shared, snp_flush;
   logic [DATA_W-1:0] snp_flush_data;

   always #(CLK_P/2) clk = ~clk;

   mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
      .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
      .cpu_resp_valid(cpu_resp_valid), .cpu_resp_rdata(cpu_resp_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
      .bus_cmd(bus_cmd), .bus_cmd_addr(bus_cmd_addr), .bus_cmd_data(bus_cmd_data),
      .bus_ack(bus_ack), .bus_fill_data(bus_fill_data), .bus_shared_in(bus_shared_in),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // ---------------- memory and bus agent ----------------
   logic [DATA_W-1:0] mem [logic [ADDR_W-1:0]];
   logic [49:0] bus_log [$];
   bit  gnt_ok    = 1'b1;
   bit  shared_drv = 1'b0;
   int  ack_cd    = 0;
   logic [1:0]        p_cmd;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_data;

   function automatic logic [DATA_W-1:0] fill_of(input logic [ADDR_W-1:0] a);
      if (mem.exists(a)) return mem[a];
      return {16'hA5A5, a};
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         bus_ack = 1'b0;
         if (ack_cd > 0) begin
            ack_cd--;
            if (ack_cd == 0) begin
               bus_ack       = 1'b1;
               bus_shared_in = shared_drv;
               bus_fill_data = fill_of(p_addr);
               if (p_cmd == C_WB) mem[p_addr] = p_data;
            end
         end
         bus_gnt = bus_req && gnt_ok;
         #1;
         if (bus_cmd_valid) begin
            bus_log.push_back({bus_cmd, bus_cmd_addr, bus_cmd_data});
            p_cmd  = bus_cmd;
            p_addr = bus_cmd_addr;
            p_data = bus_cmd_data;
            ack_cd = 2;
         end
      end
   end

   task automatic expect_bus(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input string rq);
      logic [49:0] e, got;
      e = {c, a, d};
      if (bus_log.size() == 0) begin
         chk(1'b0, rq, 64'hDEAD, {14'd0, e});
      end else begin
         got = bus_log.pop_front();
         chk(got == e, rq, {14'd0, got}, {14'd0, e});
      end
   endtask

   task automatic no_bus(input string rq);
      chk(bus_log.size() == 0, rq, 64'(bus_log.size()), 64'd0);
      bus_log.delete();
   endtask

   // ---------------- scoreboard ----------------
   logic [DATA_W-1:0] sb_q [$];
   string             sb_rq [$];

   always @(negedge clk) begin
      if (rst_n && cpu_resp_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R11 unexpected response", 64'(cpu_resp_rdata), 64'd0);
         end else begin
            logic [DATA_W-1:0] e;
            string r;
            e = sb_q.pop_front();
            r = sb_rq.pop_front();
            chk(cpu_resp_rdata == e, r, 64'(cpu_resp_rdata), 64'(e));
         end
      end
   end

   task automatic cpu_op(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input logic [DATA_W-1:0] exp,
                         input string rq);
      @(negedge clk);
      sb_q.push_back(exp);
      sb_rq.push_back(rq);
      cpu_req_valid = 1'b1;
      cpu_req_write = wr;
      cpu_req_addr  = a;
      cpu_req_wdata = wd;
      do @(negedge clk); while (!cpu_resp_valid);
      cpu_req_valid = 1'b0;
   endtask

   task automatic do_snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                           input bit e_sh, input bit e_fl,
                           input logic [DATA_W-1:0] e_d, input string rq);
      @(negedge clk);
      snp_valid = 1'b1;
      snp_cmd   = c;
      snp_addr  = a;
      #(CLK_P/4);
      chk(snp_shared == e_sh, {rq, " shared"}, 64'(snp_shared), 64'(e_sh));
      chk(snp_flush == e_fl, {rq, " flush"}, 64'(snp_flush), 64'(e_fl));
      if (e_fl) chk(snp_flush_data == e_d, {rq, " data"}, 64'(snp_flush_data), 64'(e_d));
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   task automatic finish_run();
      chk(sb_q.size() == 0, "scoreboard drained", 64'(sb_q.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   localparam logic [ADDR_W-1:0] A_ = 16'h0010;
   localparam logic [ADDR_W-1:0] B_ = 16'h0020;
   localparam logic [ADDR_W-1:0] C_ = 16'h0031;
   localparam logic [ADDR_W-1:0] D_ = 16'h0041;
   localparam logic [ADDR_W-1:0] E_ = 16'h0052;
   localparam logic [ADDR_W-1:0] F_ = 16'h0063;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(bus_req == 1'b0, "R1 bus_req after reset", 64'(bus_req), 64'd0);
      chk(cpu_resp_valid == 1'b0, "R1 resp after reset", 64'(cpu_resp_valid), 64'd0);
      do_snoop(C_RD, A_, 1'b0, 1'b0, '0, "R1 R10 snoop on invalid line");

      // R2: exclusive fill
      shared_drv = 1'b0;
      cpu_op(1'b0, A_, '0, fill_of(A_), "R2 read miss data");
      expect_bus(C_RD, A_, '0, "R1 R2 bus read on miss");
      // R5: silent write on E
      cpu_op(1'b1, A_, 32'h1111, 32'h1111, "R5 write hit E");
      no_bus("R5 no bus traffic on E write");
      // R8: snoop read on M
      do_snoop(C_RD, A_, 1'b1, 1'b1, 32'h1111, "R8 snoop read on M");
      // R3: S read hit
      cpu_op(1'b0, A_, '0, 32'h1111, "R3 read hit S");
      no_bus("R3 no bus traffic on S read");
      // R4: upgrade
      cpu_op(1'b1, A_, 32'h2222, 32'h2222, "R4 write to S");
      expect_bus(C_UPG, A_, '0, "R4 upgrade command");
      // R9: snoop rfo on M
      do_snoop(C_RDX, A_, 1'b1, 1'b1, 32'h2222, "R9 snoop rfo on M");
      shared_drv = 1'b1;
      cpu_op(1'b0, A_, '0, fill_of(A_), "R9 refill after invalidate");
      expect_bus(C_RD, A_, '0, "R9 line was invalid");
      do_snoop(C_RD, A_, 1'b1, 1'b0, '0, "R3 shared fill answers without flush");
      // R10: tag mismatch and write-back snoops
      do_snoop(C_RDX, B_, 1'b0, 1'b0, '0, "R10 tag mismatch snoop");
      do_snoop(C_WB, A_, 1'b0, 1'b0, '0, "R10 write-back snoop");
      cpu_op(1'b0, A_, '0, fill_of(A_), "R10 line kept after ignored snoops");
      no_bus("R10 still hits");

      // R6: write miss
      cpu_op(1'b1, C_, 32'h3333, 32'h3333, "R6 write miss");
      expect_bus(C_RDX, C_, '0, "R6 rfo command");
      // R7: dirty eviction
      shared_drv = 1'b0;
      cpu_op(1'b0, D_, '0, fill_of(D_), "R7 read evicting M");
      expect_bus(C_WB, C_, 32'h3333, "R7 write-back first");
      expect_bus(C_RD, D_, '0, "R7 fill after write-back");
      cpu_op(1'b0, C_, '0, 32'h3333, "R7 written-back word returns");
      expect_bus(C_RD, C_, '0, "R7 clean victim no write-back");
      no_bus("R7 no extra traffic");

      // R12 and R11: invalidate while upgrade waits for grant
      shared_drv = 1'b1;
      cpu_op(1'b0, E_, '0, fill_of(E_), "R12 shared fill");
      expect_bus(C_RD, E_, '0, "R12 fill command");
      gnt_ok = 1'b0;
      fork
         cpu_op(1'b1, E_, 32'h5555, 32'h5555, "R12 write completes");
         begin
            repeat (4) @(negedge clk);
            #2;
            chk(bus_req == 1'b1, "R11 request held", 64'(bus_req), 64'd1);
            chk(cpu_resp_valid == 1'b0, "R11 stalled", 64'(cpu_resp_valid), 64'd0);
            chk(bus_log.size() == 0, "R11 no command without grant",
                64'(bus_log.size()), 64'd0);
            do_snoop(C_UPG, E_, 1'b1, 1'b0, '0, "R12 snoop upgrade on pending S");
            gnt_ok = 1'b1;
         end
      join
      expect_bus(C_RDX, E_, '0, "R12 upgrade becomes rfo");
      do_snoop(C_RD, E_, 1'b1, 1'b1, 32'h5555, "R12 line ends M");

      // R13: snoop and local write on the same index in one cycle
      shared_drv = 1'b0;
      cpu_op(1'b0, F_, '0, fill_of(F_), "R13 exclusive fill");
      expect_bus(C_RD, F_, '0, "R13 fill command");
      fork
         cpu_op(1'b1, F_, 32'h6666, 32'h6666, "R13 write after snoop");
         do_snoop(C_RD, F_, 1'b1, 1'b0, '0, "R8 R13 snoop read on E");
      join
      expect_bus(C_UPG, F_, '0, "R13 write sees S and upgrades");
      do_snoop(C_RD, F_, 1'b1, 1'b1, 32'h6666, "R13 line ends M");
      no_bus("R13 no extra traffic");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule